// File: doc/BRIEF.md
# Multi-Source Reset Pulse Sequencer

This block is the digital core of a supply supervisor. It merges supply undervoltage flags, an auxiliary undervoltage flag, an active-low manual reset button and a watchdog expiry pulse into a system reset. When every asserting condition is gone, the reset is held for a stretch period, and then it releases. A 3-bit code picks the stretch period from a table of eight tick counts. Time is counted in cycles where the `tick` enable is high, so the block can run from any slow time base.

There are two stretch channels. The primary channel drives `rst_out_n` and its optional active-high complement `rst_out`. The secondary channel drives `rst2_n` and sees only the supply flags and the manual reset. Each channel runs a state machine with three states:

- **HOLD**: a fault is present, or the block is in its own reset.
- **STRETCH**: counting ticks with no fault present.
- **RUN**: reset released.

The state machine moves between these states as follows:

- **fault-seen**: from any state to HOLD.
- **fault-cleared**: from HOLD to STRETCH, with the count set to zero.
- **timeout-done**: from STRETCH to RUN, on the tick that completes the selected count.

A fault that appears during STRETCH takes the machine back to HOLD, so the count restarts.

Top module: `rst_seq_top`

## Requirements
- R1: Each of the following asserts `rst_out_n` (drives it to 0): a high bit of `sup_uv` (1 = undervoltage), `aux_uv` high (1 = below threshold), a qualified manual reset, or `wd_expire` high. The change shows at the output 3 clock cycles after the input changes at the port, counting two synchroniser flops and the state register.
- R2: After every asserting condition has cleared, the reset stays asserted for exactly `TO_TICKS[to_sel]` tick-enabled cycles spent in STRETCH. It then releases.
- R3: If a fault returns during STRETCH, the channel goes back to HOLD and its tick count restarts from zero.
- R4: While the manual reset is qualified and `mr_n` stays low, reset stays asserted. The stretch begins only after `mr_n` returns high.
- R5: A low pulse on `mr_n` shorter than `MR_FILT` clock cycles (after synchronisation) is ignored. A low level lasting `MR_FILT` cycles or longer qualifies as a manual reset.
- R6: `rst2_n` asserts only from `sup_uv` and the qualified manual reset; `aux_uv` and `wd_expire` have no effect on it. It uses the same stretch length as the primary channel.
- R7: When `HAS_ACT_HIGH` is 1, `rst_out` is always the logical complement of `rst_out_n`. When it is 0, `rst_out` is tied to 0.
- R8: `to_sel` code k (0 to 7) selects stretch length `TO_TICKS[k]`. The defaults correspond to 1.65, 13.2, 26.25, 52.5, 210, 420, 840 and 1680 ms at a 75 µs tick.
- R9: While `rst_n` is low, all resets are asserted. After `rst_n` goes high, the stretch starts as soon as no condition is present.
- R10: A single-cycle high pulse on `wd_expire` causes a full primary reset stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| tick | input | 1 | Time-base enable; each high cycle is one count |
| sup_uv | input | N_SUP | Per-supply undervoltage flags, 1 = fault |
| aux_uv | input | 1 | Auxiliary undervoltage flag, 1 = fault |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wd_expire | input | 1 | Watchdog expiry pulse, active high |
| to_sel | input | 3 | Stretch length select code |
| rst_out_n | output | 1 | Primary reset, active low |
| rst_out | output | 1 | Primary reset, active high (complement) |
| rst2_n | output | 1 | Secondary reset, active low |

## Verification
Suppose a channel's state machine holds a wrong state, or its count skips or stalls. The release edge of `rst_out_n` or `rst2_n` then moves by at least one tick from the reference model, so the error shows at the first release after the fault. A fault that leaks across channels shows as a stray low on `rst2_n` within three cycles of an auxiliary or watchdog event. An error in the manual-reset filter shows as a reset following a short glitch, or as no reset after a held press, within `MR_FILT` + 3 cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } stretch_st_e;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/rst_seq_mr_filt.sv
module rst_seq_mr_filt #(
    parameter int unsigned FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_s_n,
    output logic mr_act
);
    localparam int unsigned CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (mr_s_n)
            low_cnt <= '0;
        else if (low_cnt != FULL)
            low_cnt <= low_cnt + 1'b1;
    end

    always_comb mr_act = (low_cnt == FULL);

    // R5: qualification only ever follows a low synchronised level
    assert_mr_qualify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_act) |-> $past(!mr_s_n));

    // R4: a held press keeps the qualified state
    assert_mr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_act && !mr_s_n) |=> mr_act);
endmodule

// File: rtl/rst_seq_stretch.sv
module rst_seq_stretch
    import rst_seq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fault,
    input  logic [CNT_W-1:0] limit,
    output logic             asserted
);
    stretch_st_e      state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:    nxt = fault ? ST_HOLD : ST_STRETCH;
            ST_STRETCH: begin
                if (fault)                            nxt = ST_HOLD;
                else if (tick && cnt == limit - 1'b1) nxt = ST_RUN;
                else                                  nxt = ST_STRETCH;
            end
            ST_RUN:     nxt = fault ? ST_HOLD : ST_RUN;
            default:    nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (state != ST_STRETCH || fault)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    always_comb asserted = (state != ST_RUN);

    // R1: a present fault forces HOLD on the next cycle
    assert_fault_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (state == ST_HOLD));

    // R3: a fault during the stretch restarts the count
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && fault) |=> (state == ST_HOLD && cnt == '0));

    // R2: the count never reaches the limit while stretching
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH) |-> (cnt < limit));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int unsigned N_SUP        = 2,
    parameter int unsigned MR_FILT      = 4,
    parameter bit          HAS_ACT_HIGH = 1'b1,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned TO_TICKS [8] = '{22, 176, 350, 700, 2800, 5600, 11200, 22400}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N_SUP-1:0] sup_uv,
    input  logic             aux_uv,
    input  logic             mr_n,
    input  logic             wd_expire,
    input  logic [2:0]       to_sel,
    output logic             rst_out_n,
    output logic             rst_out,
    output logic             rst2_n
);
    localparam int unsigned SW = N_SUP + 2;
    localparam int unsigned NCH = 2;

    logic [SW-1:0]    flt_s;
    logic [0:0]       mr_s;
    logic             mr_act;
    logic [CNT_W-1:0] lim_tab [8];
    logic [CNT_W-1:0] limit;
    logic [NCH-1:0]   ch_fault;
    logic [NCH-1:0]   ch_asserted;
    logic             sup_any;

    rst_seq_sync #(.W(SW), .RST_VAL('0)) u_flt_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({wd_expire, aux_uv, sup_uv}),
        .q_sync(flt_s)
    );

    rst_seq_sync #(.W(1), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async(mr_n),
        .q_sync(mr_s)
    );

    rst_seq_mr_filt #(.FILT(MR_FILT)) u_mr_filt (
        .clk(clk), .rst_n(rst_n),
        .mr_s_n(mr_s[0]),
        .mr_act(mr_act)
    );

    for (genvar i = 0; i < 8; i++) begin : g_lim
        assign lim_tab[i] = CNT_W'(TO_TICKS[i]);
    end
    assign limit = lim_tab[to_sel];

    assign sup_any     = |flt_s[N_SUP-1:0];
    assign ch_fault[0] = sup_any | flt_s[N_SUP] | flt_s[N_SUP+1] | mr_act;
    assign ch_fault[1] = sup_any | mr_act;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rst_seq_stretch #(.CNT_W(CNT_W)) u_stretch (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .fault(ch_fault[c]), .limit(limit),
            .asserted(ch_asserted[c])
        );
    end

    assign rst_out_n = ~ch_asserted[0];
    assign rst2_n    = ~ch_asserted[1];

    if (HAS_ACT_HIGH) begin : g_hi
        assign rst_out = ch_asserted[0];
        // R7: active-high output mirrors the active-low one
        assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rst_out == !rst_out_n);
    end else begin : g_no_hi
        assign rst_out = 1'b0;
    end

    // R6: a released secondary channel stays released without supply or manual faults
    assert_sec_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst2_n && !sup_any && !mr_act) |=> rst2_n);

    // R1: synchronised supply fault pulls the primary reset low next cycle
    assert_sup_asserts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sup_any |=> !rst_out_n);
endmodule

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
    localparam int N_SUP = 2;
    localparam int MR_FILT = 4;
    localparam int unsigned TT [8] = '{3, 4, 5, 6, 7, 8, 9, 10};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [N_SUP-1:0] sup_uv = '0;
    logic             aux_uv = 1'b0;
    logic             mr_n = 1'b1;
    logic             wd_expire = 1'b0;
    logic [2:0]       to_sel = 3'd0;
    logic             rst_out_n, rst_out, rst2_n;

    int checks = 0;
    int fails = 0;
    string cur_req = "R9";
    bit started = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rst_seq_top #(.N_SUP(N_SUP), .MR_FILT(MR_FILT), .HAS_ACT_HIGH(1'b1),
                  .CNT_W(8), .TO_TICKS(TT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sup_uv(sup_uv), .aux_uv(aux_uv),
        .mr_n(mr_n), .wd_expire(wd_expire), .to_sel(to_sel),
        .rst_out_n(rst_out_n), .rst_out(rst_out), .rst2_n(rst2_n)
    );

    // tick every second cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 2;
        tick = (tdiv == 0);
    end

    // behavioural reference: 0 = held, 1 = stretching, 2 = released
    int m_st [2];
    int m_cnt [2];
    bit [N_SUP-1:0] ms1, ms2;
    bit ma1, ma2, mw1, mw2, mm1, mm2;
    int mrc;
    bit m_flt [2];
    bit m_mract;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin m_st[c] = 0; m_cnt[c] = 0; end
            ms1 = '0; ms2 = '0; ma1 = 0; ma2 = 0; mw1 = 0; mw2 = 0;
            mm1 = 1; mm2 = 1; mrc = 0;
        end else begin
            m_mract = (mrc == MR_FILT);
            m_flt[0] = (ms2 != 0) || ma2 || mw2 || m_mract;
            m_flt[1] = (ms2 != 0) || m_mract;
            for (int c = 0; c < 2; c++) begin
                if (m_flt[c]) begin m_st[c] = 0; m_cnt[c] = 0; end
                else if (m_st[c] == 0) begin m_st[c] = 1; m_cnt[c] = 0; end
                else if (m_st[c] == 1 && tick) begin
                    m_cnt[c] = m_cnt[c] + 1;
                    if (m_cnt[c] == int'(TT[to_sel])) m_st[c] = 2;
                end
            end
            if (mm2) mrc = 0; else if (mrc < MR_FILT) mrc = mrc + 1;
            ms2 = ms1; ms1 = sup_uv;
            ma2 = ma1; ma1 = aux_uv;
            mw2 = mw1; mw1 = wd_expire;
            mm2 = mm1; mm1 = mr_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(rst_out_n == (m_st[0] == 2), cur_req, rst_out_n, m_st[0] == 2, "rst_out_n");
            chk(rst2_n == (m_st[1] == 2), cur_req, rst2_n, m_st[1] == 2, "rst2_n");
            chk(rst_out == !rst_out_n, "R7", rst_out, !rst_out_n, "rst_out complement");
        end
    end

    int sec_low = 0;
    always @(negedge clk) if (started && !rst2_n) sec_low++;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release();
        for (int i = 0; i < 400; i++) begin
            if (rst_out_n && rst2_n) break;
            @(negedge clk);
        end
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
    endtask

    int lows;
    int s0;

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(1);
        started = 1'b1;
        cyc(4);
        // R9: reset state
        chk(!rst_out_n && !rst2_n, "R9", rst_out_n, 0, "held during block reset");
        rst_n = 1'b1;
        cur_req = "R9";
        wait_release();
        chk(rst_out_n && rst2_n, "R9", rst_out_n, 1, "release after block reset");

        // R1 / R2: supply fault then stretch
        cur_req = "R1";
        sup_uv = 2'b01;
        cyc(3);
        chk(!rst_out_n, "R1", rst_out_n, 0, "supply fault asserts after 3 cycles");
        cyc(2);
        sup_uv = '0;
        cur_req = "R2";
        wait_release();
        chk(rst_out_n, "R2", rst_out_n, 1, "release after stretch");

        // R8: every select code, via second supply flag
        for (int k = 0; k < 8; k++) begin
            cur_req = "R8";
            to_sel = 3'(k);
            sup_uv = 2'b10;
            cyc(4);
            sup_uv = '0;
            count_low(2 * int'(TT[k]) + 3, lows);
            chk(lows >= 2 * int'(TT[k]) - 1 && lows <= 2 * int'(TT[k]) + 3, "R8", lows, 2 * int'(TT[k]), "stretch length cycles");
            wait_release();
        end

        // R1 / R6: auxiliary fault leaves the secondary reset alone
        cur_req = "R6";
        to_sel = 3'd2;
        s0 = sec_low;
        aux_uv = 1'b1;
        cyc(6);
        aux_uv = 1'b0;
        wait_release();
        chk(sec_low == s0, "R6", sec_low - s0, 0, "secondary low cycles on aux fault");

        // R10 / R6: one-cycle watchdog pulse
        cur_req = "R10";
        s0 = sec_low;
        wd_expire = 1'b1;
        cyc(1);
        wd_expire = 1'b0;
        cyc(3);
        chk(!rst_out_n, "R10", rst_out_n, 0, "watchdog pulse asserts");
        wait_release();
        chk(sec_low == s0, "R6", sec_low - s0, 0, "secondary low cycles on watchdog");

        // R3: fault returns mid-stretch
        cur_req = "R3";
        to_sel = 3'd7;
        sup_uv = 2'b01;
        cyc(4);
        sup_uv = '0;
        cyc(10);
        sup_uv = 2'b01;
        cyc(1);
        sup_uv = '0;
        cyc(18);
        chk(!rst_out_n, "R3", rst_out_n, 0, "still held after restart");
        wait_release();

        // R4: held manual reset
        cur_req = "R4";
        to_sel = 3'd0;
        mr_n = 1'b0;
        cyc(30);
        chk(!rst_out_n && !rst2_n, "R4", rst_out_n, 0, "held while button low");
        mr_n = 1'b1;
        cyc(6);
        chk(!rst_out_n, "R4", rst_out_n, 0, "stretch starts after button high");
        wait_release();

        // R5: short glitch ignored, qualifying pulse accepted
        cur_req = "R5";
        mr_n = 1'b0;
        cyc(MR_FILT - 1);
        mr_n = 1'b1;
        count_low(12, lows);
        chk(lows == 0, "R5", lows, 0, "glitch shorter than filter");
        mr_n = 1'b0;
        cyc(MR_FILT);
        mr_n = 1'b1;
        count_low(10, lows);
        chk(lows > 0, "R5", lows, 1, "pulse at filter length");
        wait_release();

        // R9: block reset mid-operation
        cur_req = "R9";
        rst_n = 1'b0;
        cyc(2);
        chk(!rst_out_n && !rst2_n, "R9", rst_out_n, 0, "block reset reasserts");
        rst_n = 1'b1;
        wait_release();
        cyc(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule